// File: doc/BRIEF.md
# Multicore Global Configuration Registers

This block is a memory-mapped register file shared by the processors of a small multicore cluster. Its global part holds a relocatable base for the block itself, a fixed revision, and a base/enable register for each of two attached windows: one for an interrupt controller and one for a power controller. Each window's address field and enable bit are driven out as ports so that address decoding elsewhere can place the window and switch it on or off. Constant registers report the cluster configuration and an L2 configuration in which the cache is bypassed.

The block also keeps a register set for each virtual processor. A set holds a selector and a reset (exception) base. Every access carries the ID of the requesting processor. The core-local block addresses the requester's own set. The core-other block addresses the set of the processor named by the requester's selector, so any processor can program another processor's boot vector. Each processor's exception-base output is updated on the clock edge of the write.

Accesses use a simple strobed register bus. Read data comes back registered, one cycle after the read strobe, and is marked by a valid flag.

Top module: `cmg_regs`

## Requirements
- R1: After reset, both window registers are zero with both window enables low, every selector is 0, every reset base is 0xBFC00000, every exception-base output is 0xFFFFFFFF_BFC00000, and the block's own base is the BASE_RST parameter.
- R2: `rvalid` is high in exactly the cycle after a cycle with `rd_en` high, and `rdata` holds the read value in that cycle.
- R3: The global config at 0x000 reads 0. The revision at 0x030 reads the REV parameter (default 0x800). The L2 config at 0x130 reads 0x00100000, which is bit 20, the bypass bit. The per-processor config at 0x2010 and at 0x4010 reads NVP-1.
- R4: A write to the interrupt-window register at 0x080 stores data & 0xFFFF8001, and the register reads back that value. `irq_win_base` equals the stored value with bit 0 cleared. `irq_win_en` equals stored bit 0.
- R5: The status registers at 0x0D0 (interrupt window) and 0x0F0 (power window) read 1 when that window is present and 0 when it is absent. On an absent window, a write to its register at 0x080 or 0x088 is ignored: the register reads 0 and its outputs stay 0.
- R6: A write to 0x2020 stores data & 0xFFFFF000 as the requester's reset base. From the next cycle, that processor's 64-bit slice of `exc_base` (slice i is bits 64*i+63 to 64*i) is that value sign-extended from bit 31.
- R7: The core-other block at 0x4018 (selector) and 0x4020 (reset base) reads and writes the set of the processor whose index is held in the requester's selector. The local block at 0x2018 and 0x2020 reads and writes the requester's own set.
- R8: A selector write, local or other, takes data bits 3:0. It is accepted only when that value is less than NVP. Otherwise the selector keeps its old value.
- R9: Reads of any offset not listed here return 0. Writes to such offsets, and to read-only registers, change no register or output.
- R10: When `rd_en` and `wr_en` are both high in one cycle, the read returns the value from before the write, and the write still takes effect.
- R11: A write to 0x008 stores data & 0xFFFF8000 as the block's own base. The register reads back that value, and `own_base` drives it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| addr | input | 16 | Byte offset within the block |
| wdata | input | 32 | Write data |
| req_id | input | IDW | Index of the requesting processor |
| rdata | output | 32 | Read data, valid with rvalid |
| rvalid | output | 1 | Read data valid, one cycle after rd_en |
| own_base | output | 32 | Relocatable base of this block |
| irq_win_base | output | 32 | Interrupt-controller window base address |
| irq_win_en | output | 1 | Interrupt-controller window enable |
| pwr_win_base | output | 32 | Power-controller window base address |
| pwr_win_en | output | 1 | Power-controller window enable |
| exc_base | output | NVP*64 | Per-processor exception base, 64 bits each |

## Verification
A read and a write can share one cycle. The read mux sees the old register contents while the same edge loads the new value. The bench raises both strobes on the interrupt-window register and expects the returned data to be the value from before the write. It then reads again to confirm the new value and checks the enable port. Selector redirection is tested separately: a local selector write is followed by core-other accesses, and their effect is judged through a different requester's local block.

// File: rtl/cmg_pkg.sv
package cmg_pkg;
    // global block offsets
    localparam logic [12:0] G_CFG    = 13'h0000;
    localparam logic [12:0] G_BASE   = 13'h0008;
    localparam logic [12:0] G_REV    = 13'h0030;
    localparam logic [12:0] G_IRQW   = 13'h0080;
    localparam logic [12:0] G_PWRW   = 13'h0088;
    localparam logic [12:0] G_IRQST  = 13'h00D0;
    localparam logic [12:0] G_PWRST  = 13'h00F0;
    localparam logic [12:0] G_L2     = 13'h0130;
    // block selects on addr[15:13]
    localparam logic [2:0]  BLK_GLOB = 3'd0;
    localparam logic [2:0]  BLK_LOC  = 3'd1;
    localparam logic [2:0]  BLK_OTH  = 3'd2;
    // per-processor sub offsets
    localparam logic [12:0] P_CFG    = 13'h0010;
    localparam logic [12:0] P_SEL    = 13'h0018;
    localparam logic [12:0] P_RB     = 13'h0020;
    // field masks
    localparam logic [31:0] WIN_MASK  = 32'hFFFF_8001;
    localparam logic [31:0] ADDR_MASK = 32'hFFFF_8000;
    localparam logic [31:0] RB_MASK   = 32'hFFFF_F000;
    localparam logic [31:0] RB_RESET  = 32'hBFC0_0000;
    localparam logic [31:0] L2_BYPASS = 32'h0010_0000;
    localparam int          SELW      = 4;

    function automatic logic [63:0] sext32(input logic [31:0] v);
        return {{32{v[31]}}, v};
    endfunction
endpackage

// File: rtl/cmg_win_reg.sv
module cmg_win_reg
    import cmg_pkg::*;
#(
    parameter bit PRESENT = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr,
    input  logic [31:0] wdata,
    output logic [31:0] stored,
    output logic [31:0] base,
    output logic        en
);
    typedef struct packed {
        logic [31:0] val;
    } win_st_t;

    win_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (PRESENT && wr) begin
            st_d.val = wdata & WIN_MASK;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stored = st_q.val;
    assign base   = st_q.val & ADDR_MASK;
    assign en     = st_q.val[0];

    generate
        if (PRESENT) begin : g_present
            AST_WIN_EN_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
                wr |=> (en == $past(wdata[0])));  // R4
            AST_WIN_BASE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
                wr |=> (base == ($past(wdata) & ADDR_MASK)));  // R4
        end else begin : g_absent
            AST_WIN_ABSENT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
                wr |=> (!en && base == 32'h0));  // R5
        end
    endgenerate
endmodule

// File: rtl/cmg_vp_bank.sv
module cmg_vp_bank
    import cmg_pkg::*;
#(
    parameter int NVP = 1,
    parameter int IDW = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDW-1:0]    req_id,
    input  logic [31:0]       wdata,
    input  logic              wr_loc_sel,
    input  logic              wr_loc_rb,
    input  logic              wr_oth_sel,
    input  logic              wr_oth_rb,
    output logic              id_ok,
    output logic [SELW-1:0]   loc_sel,
    output logic [31:0]       loc_rb,
    output logic [SELW-1:0]   oth_sel,
    output logic [31:0]       oth_rb,
    output logic [NVP*64-1:0] exc_flat
);
    typedef struct packed {
        logic [NVP-1:0][SELW-1:0] sel;
        logic [NVP-1:0][31:0]     rb;
    } bank_st_t;

    bank_st_t st_d, st_q;
    int       li, oi;
    logic     sel_ok;

    always_comb begin
        st_d    = st_q;
        id_ok   = (32'(req_id) < 32'(NVP));
        li      = id_ok ? int'(req_id) : 0;
        oi      = int'(st_q.sel[li]);
        sel_ok  = (32'(wdata[SELW-1:0]) < 32'(NVP));
        loc_sel = id_ok ? st_q.sel[li] : '0;
        loc_rb  = id_ok ? st_q.rb[li]  : '0;
        oth_sel = id_ok ? st_q.sel[oi] : '0;
        oth_rb  = id_ok ? st_q.rb[oi]  : '0;
        if (id_ok) begin
            if (wr_loc_sel && sel_ok) st_d.sel[li] = wdata[SELW-1:0];
            if (wr_oth_sel && sel_ok) st_d.sel[oi] = wdata[SELW-1:0];
            if (wr_loc_rb)            st_d.rb[li]  = wdata & RB_MASK;
            if (wr_oth_rb)            st_d.rb[oi]  = wdata & RB_MASK;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NVP; i++) begin
                st_q.sel[i] <= '0;
                st_q.rb[i]  <= RB_RESET & RB_MASK;
            end
        end else begin
            st_q <= st_d;
        end
    end

    genvar gi;
    generate
        for (gi = 0; gi < NVP; gi++) begin : g_vp
            assign exc_flat[gi*64 +: 64] = sext32(st_q.rb[gi]);

            AST_SEL_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
                32'(st_q.sel[gi]) < 32'(NVP));  // R8
            AST_SEL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_loc_sel && 32'(req_id) == 32'(gi) && 32'(wdata[SELW-1:0]) >= 32'(NVP))
                |=> $stable(st_q.sel[gi]));  // R8
            AST_LOC_RB_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_loc_rb && 32'(req_id) == 32'(gi))
                |=> (exc_flat[gi*64 +: 32] == ($past(wdata) & RB_MASK)));  // R6
        end
    endgenerate
endmodule

// File: rtl/cmg_regs.sv
module cmg_regs
    import cmg_pkg::*;
#(
    parameter int          NVP         = 1,
    parameter logic [31:0] REV         = 32'h0000_0800,
    parameter bit          IRQ_PRESENT = 1'b1,
    parameter bit          PWR_PRESENT = 1'b1,
    parameter logic [31:0] BASE_RST    = 32'h1FBF_8000,
    localparam int         IDW         = (NVP > 1) ? $clog2(NVP) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [15:0]       addr,
    input  logic [31:0]       wdata,
    input  logic [IDW-1:0]    req_id,
    output logic [31:0]       rdata,
    output logic              rvalid,
    output logic [31:0]       own_base,
    output logic [31:0]       irq_win_base,
    output logic              irq_win_en,
    output logic [31:0]       pwr_win_base,
    output logic              pwr_win_en,
    output logic [NVP*64-1:0] exc_base
);
    typedef struct packed {
        logic [31:0] rdata;
        logic        rvalid;
        logic [31:0] own;
    } top_st_t;

    top_st_t st_d, st_q;

    logic [2:0]      blk;
    logic [12:0]     off;
    logic            g_hit, l_hit, o_hit;
    logic            wr_irq, wr_pwr;
    logic            wr_lsel, wr_lrb, wr_osel, wr_orb;
    logic [31:0]     irq_st, pwr_st;
    logic            id_ok;
    logic [SELW-1:0] l_sel, o_sel;
    logic [31:0]     l_rb, o_rb;
    logic [31:0]     rd_val;

    always_comb begin
        blk     = addr[15:13];
        off     = addr[12:0];
        g_hit   = (blk == BLK_GLOB);
        l_hit   = (blk == BLK_LOC);
        o_hit   = (blk == BLK_OTH);
        wr_irq  = wr_en && g_hit && off == G_IRQW;
        wr_pwr  = wr_en && g_hit && off == G_PWRW;
        wr_lsel = wr_en && l_hit && off == P_SEL;
        wr_lrb  = wr_en && l_hit && off == P_RB;
        wr_osel = wr_en && o_hit && off == P_SEL;
        wr_orb  = wr_en && o_hit && off == P_RB;

        rd_val = '0;
        if (g_hit) begin
            case (off)
                G_CFG:   rd_val = '0;
                G_BASE:  rd_val = st_q.own;
                G_REV:   rd_val = REV;
                G_IRQW:  rd_val = irq_st;
                G_PWRW:  rd_val = pwr_st;
                G_IRQST: rd_val = 32'(IRQ_PRESENT);
                G_PWRST: rd_val = 32'(PWR_PRESENT);
                G_L2:    rd_val = L2_BYPASS;
                default: rd_val = '0;
            endcase
        end else if ((l_hit || o_hit) && id_ok) begin
            case (off)
                P_CFG:   rd_val = 32'(NVP - 1);
                P_SEL:   rd_val = 32'(l_hit ? l_sel : o_sel);
                P_RB:    rd_val = l_hit ? l_rb : o_rb;
                default: rd_val = '0;
            endcase
        end

        st_d        = st_q;
        st_d.rvalid = rd_en;
        if (rd_en) st_d.rdata = rd_val;
        if (wr_en && g_hit && off == G_BASE) st_d.own = wdata & ADDR_MASK;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.rdata  <= '0;
            st_q.rvalid <= 1'b0;
            st_q.own    <= BASE_RST & ADDR_MASK;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata    = st_q.rdata;
    assign rvalid   = st_q.rvalid;
    assign own_base = st_q.own;

    cmg_win_reg #(.PRESENT(IRQ_PRESENT)) u_irq (
        .clk(clk), .rst_n(rst_n), .wr(wr_irq), .wdata(wdata),
        .stored(irq_st), .base(irq_win_base), .en(irq_win_en)
    );

    cmg_win_reg #(.PRESENT(PWR_PRESENT)) u_pwr (
        .clk(clk), .rst_n(rst_n), .wr(wr_pwr), .wdata(wdata),
        .stored(pwr_st), .base(pwr_win_base), .en(pwr_win_en)
    );

    cmg_vp_bank #(.NVP(NVP), .IDW(IDW)) u_bank (
        .clk(clk), .rst_n(rst_n), .req_id(req_id), .wdata(wdata),
        .wr_loc_sel(wr_lsel), .wr_loc_rb(wr_lrb),
        .wr_oth_sel(wr_osel), .wr_oth_rb(wr_orb),
        .id_ok(id_ok), .loc_sel(l_sel), .loc_rb(l_rb),
        .oth_sel(o_sel), .oth_rb(o_rb), .exc_flat(exc_base)
    );

    AST_RVALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rvalid);  // R2
    AST_RVALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rvalid);  // R2
    AST_STATUS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == {BLK_GLOB, G_IRQST}) |=> (rdata == 32'(IRQ_PRESENT)));  // R5
    AST_OWN_BASE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == {BLK_GLOB, G_BASE}) |=> (own_base == ($past(wdata) & ADDR_MASK)));  // R11
endmodule

// File: tb/tb_cmg_regs.sv
`timescale 1ns/1ps
module tb_cmg_regs;
    localparam int NVP = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              rd_en = 1'b0;
    logic              wr_en = 1'b0;
    logic [15:0]       addr = '0;
    logic [31:0]       wdata = '0;
    logic [1:0]        req_id = '0;
    logic [31:0]       rdata;
    logic              rvalid;
    logic [31:0]       own_base, irq_win_base, pwr_win_base;
    logic              irq_win_en, pwr_win_en;
    logic [NVP*64-1:0] exc_base;

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    cmg_regs #(.NVP(NVP), .IRQ_PRESENT(1'b1), .PWR_PRESENT(1'b0)) dut (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .req_id(req_id), .rdata(rdata), .rvalid(rvalid),
        .own_base(own_base), .irq_win_base(irq_win_base), .irq_win_en(irq_win_en),
        .pwr_win_base(pwr_win_base), .pwr_win_en(pwr_win_en), .exc_base(exc_base)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [1:0] id, input logic [31:0] d);
        @(negedge clk);
        addr = a; req_id = id; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, input logic [1:0] id, input logic [31:0] e, input string tag);
        @(negedge clk);
        addr = a; req_id = id; rd_en = 1'b1;
        exp_q.push_back(e); tag_q.push_back(tag);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic rdwr(input logic [15:0] a, input logic [1:0] id, input logic [31:0] d,
                        input logic [31:0] e, input string tag);
        @(negedge clk);
        addr = a; req_id = id; wdata = d; rd_en = 1'b1; wr_en = 1'b1;
        exp_q.push_back(e); tag_q.push_back(tag);
        @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b0;
    endtask

    // monitor: pop expected read data whenever the design marks a result
    always @(negedge clk) begin
        if (rst_n && rvalid) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R2 unexpected rvalid actual=%h expected=none", rdata);
            end else begin
                automatic logic [31:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                if (rdata !== e) begin
                    errors++;
                    $display("FAIL %s actual=%h expected=%h", t, rdata, e);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL R2 watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 irq base", 64'(irq_win_base), 64'h0);
        chk("R1 irq en", 64'(irq_win_en), 64'h0);
        chk("R1 own base", 64'(own_base), 64'h1FBF_8000);
        for (int i = 0; i < NVP; i++)
            chk("R1 exc base", exc_base[i*64 +: 64], 64'hFFFF_FFFF_BFC0_0000);
        chk("R2 rvalid idle", 64'(rvalid), 64'h0);
        rd(16'h2018, 2'd0, 32'h0, "R1 selector");
        rd(16'h2020, 2'd2, 32'hBFC0_0000, "R1 reset base");
        // R3 constants
        rd(16'h0000, 2'd0, 32'h0, "R3 global cfg");
        rd(16'h0030, 2'd0, 32'h0000_0800, "R3 revision");
        rd(16'h0130, 2'd0, 32'h0010_0000, "R3 l2 cfg");
        rd(16'h2010, 2'd1, 32'd3, "R3 local cfg");
        rd(16'h4010, 2'd3, 32'd3, "R3 other cfg");
        // R4 window register
        wr(16'h0080, 2'd0, 32'h1234_5677);
        chk("R4 irq base out", 64'(irq_win_base), 64'h1234_0000);
        chk("R4 irq en out", 64'(irq_win_en), 64'h1);
        rd(16'h0080, 2'd0, 32'h1234_0001, "R4 readback");
        // R5 presence
        rd(16'h00D0, 2'd0, 32'h1, "R5 irq status");
        rd(16'h00F0, 2'd0, 32'h0, "R5 pwr status");
        wr(16'h0088, 2'd0, 32'hFFFF_FFFF);
        chk("R5 pwr en", 64'(pwr_win_en), 64'h0);
        chk("R5 pwr base", 64'(pwr_win_base), 64'h0);
        rd(16'h0088, 2'd0, 32'h0, "R5 pwr readback");
        // R6 local reset base
        wr(16'h2020, 2'd2, 32'h8000_1FFF);
        chk("R6 exc2", exc_base[2*64 +: 64], 64'hFFFF_FFFF_8000_1000);
        wr(16'h2020, 2'd1, 32'h1234_5678);
        chk("R6 exc1", exc_base[1*64 +: 64], 64'h0000_0000_1234_5000);
        chk("R6 exc0 untouched", exc_base[0 +: 64], 64'hFFFF_FFFF_BFC0_0000);
        rd(16'h2020, 2'd1, 32'h1234_5000, "R6 readback");
        // R8 selector range
        wr(16'h2018, 2'd1, 32'h0000_0005);
        rd(16'h2018, 2'd1, 32'h0, "R8 dropped");
        wr(16'h2018, 2'd1, 32'h0000_0013);
        rd(16'h2018, 2'd1, 32'h3, "R8 accepted masked");
        // R7 other window via selector of processor 1 (=3)
        wr(16'h4020, 2'd1, 32'h0ABC_DFFF);
        chk("R7 exc3", exc_base[3*64 +: 64], 64'h0000_0000_0ABC_D000);
        chk("R7 exc1 kept", exc_base[1*64 +: 64], 64'h0000_0000_1234_5000);
        rd(16'h2020, 2'd3, 32'h0ABC_D000, "R7 target local view");
        rd(16'h4020, 2'd1, 32'h0ABC_D000, "R7 other view");
        wr(16'h4018, 2'd1, 32'h0000_0002);
        rd(16'h2018, 2'd3, 32'h2, "R7 other selector write");
        rd(16'h4018, 2'd1, 32'h2, "R7 other selector read");
        rd(16'h2018, 2'd1, 32'h3, "R7 own selector kept");
        wr(16'h4018, 2'd1, 32'h0000_0009);
        rd(16'h2018, 2'd3, 32'h2, "R8 other dropped");
        // R9 unmapped and read-only
        rd(16'h0200, 2'd0, 32'h0, "R9 unmapped read");
        rd(16'h6000, 2'd0, 32'h0, "R9 unmapped block");
        wr(16'h0010, 2'd0, 32'hFFFF_FFFF);
        wr(16'h0030, 2'd0, 32'h0000_0001);
        wr(16'h2010, 2'd0, 32'h0000_0007);
        rd(16'h0080, 2'd0, 32'h1234_0001, "R9 irq kept");
        rd(16'h0030, 2'd0, 32'h0000_0800, "R9 revision kept");
        rd(16'h2010, 2'd0, 32'd3, "R9 cfg kept");
        chk("R9 own kept", 64'(own_base), 64'h1FBF_8000);
        // R10 same-cycle read and write
        rdwr(16'h0080, 2'd0, 32'h0000_8000, 32'h1234_0001, "R10 old value");
        chk("R10 en after write", 64'(irq_win_en), 64'h0);
        rd(16'h0080, 2'd0, 32'h0000_8000, "R10 new value");
        // R11 own base
        wr(16'h0008, 2'd0, 32'hABCD_FFFF);
        chk("R11 own base out", 64'(own_base), 64'hABCD_8000);
        rd(16'h0008, 2'd0, 32'hABCD_8000, "R11 readback");

        repeat (3) @(negedge clk);
        chk("R2 all reads answered", 64'(exp_q.size()), 64'h0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule